// File: doc/BRIEF.md
# DRAM Initialization Command Mode Translator

This block sits between a host memory request port and an SDRAM command/address bus during power-up bring-up. Software writes a 3-bit mode field. While the field holds one of the bring-up codes, each host memory access becomes one fixed DRAM command: no-operation, precharge of all banks, mode register load, extended mode register load or auto refresh. For the two register-load codes, host address bits [13:3] supply the value placed on the DRAM address lines. Each access is acknowledged in a single cycle and has no data phase.

The block also owns the clock-enable outputs. They stay low from reset until the first write of a non-zero mode value. A suspend request first lets any command already on the bus finish. It then precharges all banks and puts the devices into self-refresh, and holds the block there until the next reset. In normal mode (code 111) the block issues nothing and only raises a flag for downstream logic. A fast chip-select option can be granted only outside the bring-up codes, and a refused request leaves a sticky error flag. A constant type output reports the DDR device class.

Top module: `dram_init_xlate`

## Requirements
- R1: After reset the mode field is 000, every cke bit is 0, and the bus is deselected (cs_n, ras_n, cas_n, we_n all 1, bank and address 0). host_ack, fast_cs, fcs_err and normal_mode are 0, and dram_type reads 01.
- R2: cke stays 0 after reset until a config write carries a non-zero mode. In the cycle after that write, all cke bits are 1 together. A write of 000 leaves cke at 0.
- R3: In modes 001 to 110, a host_req sampled while the bus is free is acknowledged. host_ack is 1 for exactly one cycle, the cycle after the request edge, and the command is on the bus in that same cycle. In modes 000 and 111, requests are not acknowledged and the bus stays deselected.
- R4: The command encoding {cs_n,ras_n,cas_n,we_n} depends on the mode. Mode 001 gives no-operation 0111 with address 0. Mode 010 gives precharge-all 0010 with address bit 10 set and every other address bit 0. Mode 110 gives auto refresh 0001 with address 0. In all three, the bank is 00.
- R5: Modes 011 and 100 give the register-load encoding 0000. The bank is 00 for mode 011 and 01 for mode 100. cmd_addr[10:0] equals host_addr_mr (host address bits [13:3]), and all higher address bits are 0.
- R6: Reserved mode 101 acknowledges accesses but keeps the bus deselected (1111). A write of 101 still sets cke to 1.
- R7: Every command occupies the bus for one cycle, and the cycle after it is deselected. A host_req held high is therefore acknowledged every second cycle.
- R8: normal_mode is 1 exactly while the mode field holds 111. It follows a config write by one cycle.
- R9: A config write loads fast_cs from cfg_fcs when the written mode is 000 or 111. When the written mode is 001 to 110, fast_cs becomes 0. If cfg_fcs was 1 on such a write, fcs_err is set and stays 1 until reset.
- R10: The suspend sequence runs as follows. A suspend_req sampled with the bus free puts precharge-all (0010, address bit 10 set) on the bus in the next cycle. One deselected cycle follows. Then comes self-refresh entry (0001) with cke going to 0 in the same cycle. From then until reset, cke stays 0, the bus stays deselected, host requests get no acknowledge, and config writes have no effect.
- R11: If a command is on the bus when suspend_req is sampled, that command completes first. The precharge-all follows after one deselected cycle, and the rest of the suspend sequence is unchanged.
- R12: After a reset that follows a suspend, the block returns to the R1 state. cke then rises again only on a non-zero mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Config write strobe |
| cfg_mode | input | 3 | Mode value written |
| cfg_fcs | input | 1 | Fast chip-select request written with the mode |
| host_req | input | 1 | Host memory access request |
| host_addr_mr | input | MRW (11) | Host address bits [13:3] |
| suspend_req | input | 1 | Request to enter self-refresh |
| cke | output | NCKE (2) | DRAM clock enables |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BW (2) | Bank address |
| cmd_addr | output | RA (13) | DRAM address lines |
| host_ack | output | 1 | One-cycle access acknowledge |
| normal_mode | output | 1 | Mode field holds 111 |
| fast_cs | output | 1 | Fast chip-select granted |
| fcs_err | output | 1 | Sticky flag for a refused fast chip-select request |
| dram_type | output | 2 | Device class, constant 01 (DDR) |

## Verification
The assertions assume a synchronous, active-low reset held for at least one clock edge. They also assume that config writes and host requests may arrive in any cycle, including during a suspend sequence. The clock-enable rule further relies on cke being changed only by config writes and by self-refresh entry. The stimulus drives every input on the falling edge and makes random mode writes with random fast-select bits. After each command it leaves one free cycle before the next access, so that each acknowledge can be predicted. Held requests, suspend arriving with and without a command in flight, and writes after self-refresh are applied as directed cases.

// File: rtl/dinit_pkg.sv
package dinit_pkg;
  typedef enum logic [2:0] {
    M_OFF    = 3'd0,
    M_NOP    = 3'd1,
    M_PREA   = 3'd2,
    M_MRS    = 3'd3,
    M_EMRS   = 3'd4,
    M_RSVD   = 3'd5,
    M_REF    = 3'd6,
    M_NORMAL = 3'd7
  } mode_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } dcmd_t;

  localparam dcmd_t CMD_IDLE = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam dcmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam dcmd_t CMD_PREA = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam dcmd_t CMD_LMR  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
  localparam dcmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  localparam logic [1:0] TYPE_DDR = 2'b01;

  // bring-up codes: every value except off and normal
  function automatic logic is_special(input logic [2:0] m);
    return (m != 3'd0) && (m != 3'd7);
  endfunction

  function automatic dcmd_t mode_cmd(input logic [2:0] m);
    case (mode_e'(m))
      M_NOP:         return CMD_NOP;
      M_PREA:        return CMD_PREA;
      M_MRS, M_EMRS: return CMD_LMR;
      M_REF:         return CMD_REF;
      default:       return CMD_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/dinit_cfg.sv
module dinit_cfg
  import dinit_pkg::*;
#(
  parameter int NCKE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_mode,
  input  logic            cfg_fcs,
  input  logic            sr_enter,
  input  logic            sr_hold,
  output logic [2:0]      mode_q,
  output logic [NCKE-1:0] cke,
  output logic            fast_cs,
  output logic            fcs_err,
  output logic            wr_take
);
  logic fcs_reject;

  assign wr_take    = cfg_wr && !sr_hold;
  assign fcs_reject = wr_take && cfg_fcs && is_special(cfg_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 3'd0;
      cke     <= '0;
      fast_cs <= 1'b0;
      fcs_err <= 1'b0;
    end else begin
      if (sr_enter)
        cke <= '0;
      else if (wr_take && cfg_mode != 3'd0)
        cke <= '1;
      if (wr_take) begin
        mode_q  <= cfg_mode;
        fast_cs <= cfg_fcs && !is_special(cfg_mode);
      end
      if (fcs_reject)
        fcs_err <= 1'b1;
    end
  end
endmodule

// File: rtl/dinit_seq.sv
module dinit_seq
  import dinit_pkg::*;
#(
  parameter int MRW = 11,
  parameter int RA  = 13,
  parameter int BW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     mode_q,
  input  logic           host_req,
  input  logic [MRW-1:0] host_addr_mr,
  input  logic           suspend_req,
  output dcmd_t          cmd_q,
  output logic [BW-1:0]  ba_q,
  output logic [RA-1:0]  addr_q,
  output logic           host_ack,
  output logic           sr_enter,
  output logic           sr_hold,
  output logic           accept,
  output logic           susp_start
);
  typedef enum logic [1:0] {S_RUN, S_GAP, S_SR, S_HOLD} sst_e;

  localparam int A10 = 10;

  sst_e st;
  logic busy_q, pend_q, susp_any;

  function automatic logic [RA-1:0] addr_for(input logic [2:0] m, input logic [MRW-1:0] ha);
    logic [RA-1:0] r;
    r = '0;
    case (mode_e'(m))
      M_PREA:        r[A10] = 1'b1;
      M_MRS, M_EMRS: r[MRW-1:0] = ha;
      default:       r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [BW-1:0] bank_for(input logic [2:0] m);
    return (mode_e'(m) == M_EMRS) ? BW'(1) : '0;
  endfunction

  assign susp_any   = suspend_req || pend_q;
  assign susp_start = susp_any && !busy_q && st == S_RUN;
  assign accept     = host_req && is_special(mode_q) && !busy_q &&
                      st == S_RUN && !susp_any;
  assign sr_enter   = (st == S_SR);
  assign sr_hold    = (st != S_RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= CMD_IDLE;
      ba_q     <= '0;
      addr_q   <= '0;
      host_ack <= 1'b0;
      busy_q   <= 1'b0;
      pend_q   <= 1'b0;
      st       <= S_RUN;
    end else begin
      cmd_q    <= CMD_IDLE;
      ba_q     <= '0;
      addr_q   <= '0;
      host_ack <= accept;
      busy_q   <= accept || susp_start;
      pend_q   <= (st == S_RUN) && susp_any && !susp_start;
      case (st)
        S_RUN: begin
          if (susp_start) begin
            cmd_q       <= CMD_PREA;
            addr_q[A10] <= 1'b1;
            st          <= S_GAP;
          end else if (accept) begin
            cmd_q  <= mode_cmd(mode_q);
            ba_q   <= bank_for(mode_q);
            addr_q <= addr_for(mode_q, host_addr_mr);
          end
        end
        S_GAP: st <= S_SR;
        S_SR: begin
          cmd_q <= CMD_REF;
          st    <= S_HOLD;
        end
        default: st <= S_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/dram_init_xlate.sv
module dram_init_xlate
  import dinit_pkg::*;
#(
  parameter int MRW  = 11,
  parameter int RA   = 13,
  parameter int BW   = 2,
  parameter int NCKE = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [2:0]      cfg_mode,
  input  logic            cfg_fcs,
  input  logic            host_req,
  input  logic [MRW-1:0]  host_addr_mr,
  input  logic            suspend_req,
  output logic [NCKE-1:0] cke,
  output logic            cmd_cs_n,
  output logic            cmd_ras_n,
  output logic            cmd_cas_n,
  output logic            cmd_we_n,
  output logic [BW-1:0]   cmd_ba,
  output logic [RA-1:0]   cmd_addr,
  output logic            host_ack,
  output logic            normal_mode,
  output logic            fast_cs,
  output logic            fcs_err,
  output logic [1:0]      dram_type
);
  logic [2:0] mode_q;
  logic       sr_enter, sr_hold, wr_take, accept, susp_start;
  dcmd_t      cmd_q;

  dinit_cfg #(.NCKE(NCKE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_fcs(cfg_fcs), .sr_enter(sr_enter), .sr_hold(sr_hold),
    .mode_q(mode_q), .cke(cke), .fast_cs(fast_cs), .fcs_err(fcs_err),
    .wr_take(wr_take)
  );

  dinit_seq #(.MRW(MRW), .RA(RA), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .host_req(host_req),
    .host_addr_mr(host_addr_mr), .suspend_req(suspend_req),
    .cmd_q(cmd_q), .ba_q(cmd_ba), .addr_q(cmd_addr), .host_ack(host_ack),
    .sr_enter(sr_enter), .sr_hold(sr_hold), .accept(accept),
    .susp_start(susp_start)
  );

  assign cmd_cs_n    = cmd_q.cs_n;
  assign cmd_ras_n   = cmd_q.ras_n;
  assign cmd_cas_n   = cmd_q.cas_n;
  assign cmd_we_n    = cmd_q.we_n;
  assign normal_mode = (mode_q == 3'(M_NORMAL));
  assign dram_type   = TYPE_DDR;
endmodule

// File: rtl/dinit_chk.sv
module dinit_chk #(
  parameter int NCKE = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_wr,
  input logic [2:0]      cfg_mode,
  input logic            host_ack,
  input logic            cmd_cs_n,
  input logic [NCKE-1:0] cke,
  input logic            fast_cs,
  input logic            fcs_err,
  input logic [2:0]      mode_q,
  input logic            sr_enter,
  input logic            sr_hold,
  input logic            accept,
  input logic            susp_start
);
  // R2
  cke_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke == '0) || (cke == '1));
  // R2
  cke_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke[0]) |-> ($past(cfg_wr) && $past(cfg_mode) != 3'd0));
  // R3
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);
  // R3
  ack_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> host_ack);
  // R7
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_cs_n |=> cmd_cs_n);
  // R9
  fcs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_cs |-> (mode_q == 3'd0 || mode_q == 3'd7));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_err |=> fcs_err);
  // R10
  sr_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter |=> (cke == '0));
  // R10
  sr_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_hold && cke == '0) |=> (cke == '0 && !host_ack));
  // R11
  susp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(susp_start && accept));
endmodule

bind dram_init_xlate dinit_chk #(.NCKE(NCKE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
  .host_ack(host_ack), .cmd_cs_n(cmd_cs_n), .cke(cke), .fast_cs(fast_cs),
  .fcs_err(fcs_err), .mode_q(mode_q), .sr_enter(sr_enter),
  .sr_hold(sr_hold), .accept(accept), .susp_start(susp_start)
);

// File: tb/dram_init_xlate_bench.sv
module dram_init_xlate_bench;
  localparam int MRW = 11, RA = 13, BW = 2, NCKE = 2;
  localparam int BUSW = 4 + BW + RA;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, cfg_fcs = 1'b0, host_req = 1'b0, suspend_req = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic [MRW-1:0] host_addr_mr = '0;
  logic [NCKE-1:0] cke;
  logic cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n;
  logic [BW-1:0] cmd_ba;
  logic [RA-1:0] cmd_addr;
  logic host_ack, normal_mode, fast_cs, fcs_err;
  logic [1:0] dram_type;
  logic [BUSW-1:0] bus;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [2:0] e_mode;
  bit e_cke, e_fast, e_err, e_sr;

  always #10 clk = ~clk;

  dram_init_xlate #(.MRW(MRW), .RA(RA), .BW(BW), .NCKE(NCKE)) u_dram_init_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_fcs(cfg_fcs), .host_req(host_req), .host_addr_mr(host_addr_mr),
    .suspend_req(suspend_req), .cke(cke), .cmd_cs_n(cmd_cs_n),
    .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .host_ack(host_ack),
    .normal_mode(normal_mode), .fast_cs(fast_cs), .fcs_err(fcs_err),
    .dram_type(dram_type)
  );

  assign bus = {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_ba, cmd_addr};

  localparam logic [BUSW-1:0] IDLE_BUS = {4'b1111, {BW{1'b0}}, {RA{1'b0}}};
  localparam logic [BUSW-1:0] PREA_BUS = {4'b0010, {BW{1'b0}}, RA'(13'h400)};
  localparam logic [BUSW-1:0] SREF_BUS = {4'b0001, {BW{1'b0}}, {RA{1'b0}}};

  function automatic bit bring_up(input logic [2:0] m);
    return m inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
  endfunction

  function automatic logic [BUSW-1:0] want_bus(input logic [2:0] m, input logic [MRW-1:0] a);
    logic [RA-1:0] za;
    za = RA'(a);
    case (m)
      3'd1: return {4'b0111, BW'(0), RA'(0)};
      3'd2: return PREA_BUS;
      3'd3: return {4'b0000, BW'(0), za};
      3'd4: return {4'b0000, BW'(1), za};
      3'd6: return {4'b0001, BW'(0), RA'(0)};
      default: return IDLE_BUS;
    endcase
  endfunction

  function automatic string tag_for(input logic [2:0] m);
    if (m == 3'd3 || m == 3'd4) return "R5";
    if (m == 3'd5) return "R6";
    if (m == 3'd0 || m == 3'd7) return "R3";
    return "R4";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_state(input string req);
    chk(req, 32'(cke), e_cke ? 32'(3) : 32'(0));
    chk(req, 32'(fast_cs), 32'(e_fast));
    chk(req, 32'(fcs_err), 32'(e_err));
    chk("R8", 32'(normal_mode), 32'(e_mode == 3'd7));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_wr = 1'b0; host_req = 1'b0; suspend_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    e_mode = 3'd0; e_cke = 0; e_fast = 0; e_err = 0; e_sr = 0;
  endtask

  task automatic wr_cfg(input logic [2:0] m, input bit f, input string req);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mode = m; cfg_fcs = f;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (!e_sr) begin
      e_mode = m;
      if (m != 3'd0) e_cke = 1;
      e_fast = f && !bring_up(m);
      if (f && bring_up(m)) e_err = 1;
    end
    cfg_state(req);
  endtask

  task automatic access(input logic [MRW-1:0] a);
    bit hit;
    @(negedge clk);
    host_req = 1'b1; host_addr_mr = a;
    @(negedge clk);
    host_req = 1'b0;
    hit = bring_up(e_mode) && !e_sr;
    chk(e_sr ? "R10" : "R3", 32'(host_ack), 32'(hit));
    chk(e_sr ? "R10" : tag_for(e_mode), 32'(bus), hit ? 32'(want_bus(e_mode, a)) : 32'(IDLE_BUS));
    @(negedge clk);
    chk("R7", 32'(bus), 32'(IDLE_BUS));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1", 32'(bus), 32'(IDLE_BUS));
    chk("R1", 32'(cke), 0);
    chk("R1", 32'(host_ack), 0);
    chk("R1", 32'(dram_type), 32'd1);
    cfg_state("R1");
    access(11'h5A5);             // mode 000: ignored (R3)

    wr_cfg(3'd0, 0, "R2");       // R2 zero write keeps cke low
    wr_cfg(3'd5, 0, "R6");       // R6 reserved still releases cke
    access(11'h7FF);
    wr_cfg(3'd7, 1, "R9");       // R9 grant
    access(11'h123);
    wr_cfg(3'd2, 0, "R9");       // R9 special clears
    access(11'h0F0);
    wr_cfg(3'd3, 1, "R9");       // R9 refused, error set
    access(11'h7FF);
    wr_cfg(3'd4, 0, "R9");
    access(11'h401);
    wr_cfg(3'd7, 0, "R9");       // R9 error sticky
    wr_cfg(3'd6, 0, "R4");
    access(11'h001);

    // R7 held request: ack every second cycle
    wr_cfg(3'd1, 0, "R7");
    @(negedge clk);
    host_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R7", 32'(host_ack), 32'(i % 2 == 0));
    end
    host_req = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 150; i++) begin
      logic [2:0] m;
      m = 3'($urandom % 8);
      wr_cfg(m, bit'($urandom % 4 == 0), "R9");
      access(MRW'($urandom));
      access(MRW'($urandom));
    end

    // R10 suspend from idle bus
    do_reset();
    wr_cfg(3'd1, 0, "R2");
    @(negedge clk);
    suspend_req = 1'b1;
    @(negedge clk);
    suspend_req = 1'b0;
    chk("R10", 32'(bus), 32'(PREA_BUS));
    chk("R10", 32'(cke), 3);
    @(negedge clk);
    chk("R10", 32'(bus), 32'(IDLE_BUS));
    @(negedge clk);
    chk("R10", 32'(bus), 32'(SREF_BUS));
    chk("R10", 32'(cke), 0);
    e_cke = 0; e_sr = 1;
    @(negedge clk);
    chk("R10", 32'(bus), 32'(IDLE_BUS));
    access(11'h3C3);
    wr_cfg(3'd7, 1, "R10");      // ignored while in self-refresh

    // R12 reset after suspend
    do_reset();
    @(negedge clk);
    chk("R12", 32'(bus), 32'(IDLE_BUS));
    cfg_state("R12");
    access(11'h055);

    // R11 suspend during an in-flight command
    wr_cfg(3'd3, 0, "R12");
    @(negedge clk);
    host_req = 1'b1; host_addr_mr = 11'h2AB;
    @(negedge clk);
    host_req = 1'b0; suspend_req = 1'b1;
    chk("R11", 32'(host_ack), 1);
    chk("R11", 32'(bus), 32'(want_bus(3'd3, 11'h2AB)));
    @(negedge clk);
    suspend_req = 1'b0;
    chk("R11", 32'(bus), 32'(IDLE_BUS));
    @(negedge clk);
    chk("R11", 32'(bus), 32'(PREA_BUS));
    @(negedge clk);
    chk("R11", 32'(bus), 32'(IDLE_BUS));
    @(negedge clk);
    chk("R11", 32'(bus), 32'(SREF_BUS));
    chk("R11", 32'(cke), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule